// File: doc/BRIEF.md
# Command/Status Flash Bank Erase-and-Program Sequencer

This block erases or byte-programs one bank of a parallel 8-bit flash device that is driven through command bytes and a status register. A host picks an operation and a bank and pulses `start`. The sequencer then does the rest on its own. It issues the command bytes on the flash bus and polls the status register until the device reports completion, giving up after a bounded number of polls. It clears the status and returns the device to array-read mode. Finally it reads the whole bank back to confirm the result.

For a write, program data comes from a byte-wide synchronous source that returns the byte at a presented offset one cycle later. Each byte gets its own setup command, a settling gap, the data write and a status poll. A byte whose poll runs out abandons the rest of the pass. The host sees `busy`, a one-cycle `done`, and two sticky flags: `timeout` and `verifyFail`.

Every bus access takes one address-setup cycle followed by `ACC_CYC` cycles with the strobe low. The settling gap and the poll limit are parameters, and so is the bank size.

Top module: `flash_seq`

## Requirements
- R1: While reset is held and afterwards in idle, `busy`, `done`, `timeout` and `verifyFail` are low, and both `flashWeN` and `flashOeN` are high.
- R2: A `start` pulse seen while idle latches `opWrite` (1 = write, 0 = erase) and `bankSel`, and `busy` is high from the next cycle. A `start` seen while `busy` is high has no effect.
- R3: An erase writes 0x20 and then 0xD0 to the bank base. Bank N's base is N × `BANK_BYTES`, and no address outside the selected bank is written.
- R4: Polling writes 0x70 to the bank base and then reads that address; bit 7 of the byte read means complete. After `POLL_MAX` reads without bit 7, the operation sets `timeout`.
- R5: Each byte is programmed by writing 0x40 to its address, waiting at least `GAP_CYC` cycles, writing the source byte for that offset to the same address, and then polling.
- R6: A poll timeout during a write ends programming, so no later byte of the bank gets a data write.
- R7: Every operation, including one that timed out, ends its command traffic with 0x50 and then 0xFF written to the bank base.
- R8: Read-back then compares every byte, in offset order, against 0xFF after an erase or against the source byte after a write. The first mismatch sets `verifyFail` and ends the operation.
- R9: `done` is high for exactly one cycle at the end of each operation, and `busy` falls on the following cycle. `timeout` and `verifyFail` hold their value until the next accepted `start`.
- R10: While `flashWeN` stays low, `flashAddr` and `flashDqOut` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opWrite | input | 1 | 1 = program the bank, 0 = erase it |
| bankSel | input | BANK_W | Bank to operate on |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| timeout | output | 1 | A status poll ran out of attempts |
| verifyFail | output | 1 | Read-back found a wrong byte |
| srcOffset | output | OFF_W | Offset requested from the data source |
| srcData | input | 8 | Source byte, valid one cycle after its offset |
| flashAddr | output | ADDR_W | Flash byte address |
| flashDqOut | output | 8 | Byte driven on the flash data bus |
| flashDqIn | input | 8 | Byte read from the flash data bus |
| flashWeN | output | 1 | Active-low write strobe |
| flashOeN | output | 1 | Active-low output-enable strobe |

## Verification
The bench builds the sequencer with 16-byte banks, two banks, two strobe cycles per access, a three-cycle settling gap and a poll limit of eight. Its behavioural flash model stays busy long enough that every operation needs more than one poll. With these values a full bank pass, an exhausted poll budget and an aborted write all finish within a few hundred cycles. That makes every exit path reachable in one short run, including an erase that hangs on a previously written bank and a write that stops after its first byte.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_STATUS_RD   = 8'h70;
  localparam logic [7:0] CMD_STATUS_CLR  = 8'h50;
  localparam logic [7:0] CMD_ARRAY_MODE  = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ER_SETUP, ST_ER_GO, ST_PG_SETUP, ST_PG_GAP, ST_PG_DATA,
    ST_POLL_CMD, ST_POLL_READ, ST_CLEAR, ST_ARRAY, ST_VERIFY, ST_FINISH
  } seqState_t;

  typedef struct packed {
    logic       busWr;
    logic       busRd;
    logic       useOffset;
    logic       dataFromSrc;
    logic [7:0] cmd;
    logic       gapRun;
    logic       latch;
    logic       clrByte;
    logic       incByte;
    logic       clrPoll;
    logic       incPoll;
    logic       setTimeout;
    logic       setVerifyFail;
  } seqStrobe_t;

endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int BANK_BYTES = 8192,
  parameter int N_BANKS    = 2,
  parameter int ACC_CYC    = 2,
  parameter int GAP_CYC    = 100,
  parameter int POLL_MAX   = 1000000,
  localparam int OFF_W     = $clog2(BANK_BYTES),
  localparam int BANK_W    = $clog2(N_BANKS),
  localparam int ADDR_W    = OFF_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        stb,
  input  logic [BANK_W-1:0] startBank,
  input  logic              startOpWrite,
  input  logic [7:0]        srcData,
  input  logic [7:0]        flashDqIn,
  output logic [OFF_W-1:0]  srcOffset,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashDqOut,
  output logic              flashWeN,
  output logic              flashOeN,
  output logic              accDone,
  output logic              gapDone,
  output logic              devReady,
  output logic              lastByte,
  output logic              pollExhausted,
  output logic              readMatch,
  output logic              opIsWrite,
  output logic              timeoutFlag,
  output logic              verifyFailFlag
);

  localparam int TMR_MAX = (ACC_CYC > GAP_CYC) ? ACC_CYC : GAP_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int POLL_W  = $clog2(POLL_MAX + 1);

  logic [TMR_W-1:0]  timer;
  logic [OFF_W-1:0]  byteCnt;
  logic [POLL_W-1:0] pollCnt;
  logic [BANK_W-1:0] bankReg;
  logic              accActive;

  assign accActive = stb.busWr | stb.busRd;
  assign accDone   = accActive && (timer == TMR_W'(ACC_CYC));
  assign gapDone   = stb.gapRun && (timer == TMR_W'(GAP_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer <= '0;
    end else if (accDone || gapDone) begin
      timer <= '0;
    end else if (accActive || stb.gapRun) begin
      timer <= timer + 1'b1;
    end else begin
      timer <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byteCnt        <= '0;
      pollCnt        <= '0;
      bankReg        <= '0;
      opIsWrite      <= 1'b0;
      timeoutFlag    <= 1'b0;
      verifyFailFlag <= 1'b0;
    end else begin
      if (stb.latch) begin
        bankReg        <= startBank;
        opIsWrite      <= startOpWrite;
        timeoutFlag    <= 1'b0;
        verifyFailFlag <= 1'b0;
      end
      if (stb.clrByte)      byteCnt <= '0;
      else if (stb.incByte) byteCnt <= byteCnt + 1'b1;
      if (stb.clrPoll)      pollCnt <= '0;
      else if (stb.incPoll) pollCnt <= pollCnt + 1'b1;
      if (stb.setTimeout)    timeoutFlag    <= 1'b1;
      if (stb.setVerifyFail) verifyFailFlag <= 1'b1;
    end
  end

  assign srcOffset     = byteCnt;
  assign flashAddr     = {bankReg, (stb.useOffset ? byteCnt : OFF_W'(0))};
  assign flashDqOut    = stb.dataFromSrc ? srcData : stb.cmd;
  assign flashWeN      = !(stb.busWr && (timer != '0));
  assign flashOeN      = !(stb.busRd && (timer != '0));
  assign devReady      = flashDqIn[7];
  assign lastByte      = (byteCnt == OFF_W'(BANK_BYTES - 1));
  assign pollExhausted = (pollCnt == POLL_W'(POLL_MAX - 1));
  assign readMatch     = (flashDqIn == (opIsWrite ? srcData : 8'hFF));

  // R4: the poll counter never runs past its budget
  assert_poll_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pollCnt < POLL_W'(POLL_MAX));

  // R10: address and data held for the whole write strobe
  assert_write_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flashWeN && $past(!flashWeN)) |-> ($stable(flashAddr) && $stable(flashDqOut)));

  // R10: the two strobes are never low together
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!flashWeN && !flashOeN));

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       startOpWrite,
  input  logic       opIsWrite,
  input  logic       accDone,
  input  logic       gapDone,
  input  logic       devReady,
  input  logic       lastByte,
  input  logic       pollExhausted,
  input  logic       readMatch,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       done
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (start) begin
        stb.latch   = 1'b1;
        stb.clrByte = 1'b1;
        nextState   = startOpWrite ? ST_PG_SETUP : ST_ER_SETUP;
      end
      ST_ER_SETUP: begin
        stb.busWr = 1'b1;
        stb.cmd   = CMD_ERASE_SETUP;
        if (accDone) nextState = ST_ER_GO;
      end
      ST_ER_GO: begin
        stb.busWr = 1'b1;
        stb.cmd   = CMD_ERASE_GO;
        if (accDone) begin
          stb.clrPoll = 1'b1;
          nextState   = ST_POLL_CMD;
        end
      end
      ST_PG_SETUP: begin
        stb.busWr     = 1'b1;
        stb.useOffset = 1'b1;
        stb.cmd       = CMD_PROG_SETUP;
        if (accDone) nextState = ST_PG_GAP;
      end
      ST_PG_GAP: begin
        stb.gapRun    = 1'b1;
        stb.useOffset = 1'b1;
        if (gapDone) nextState = ST_PG_DATA;
      end
      ST_PG_DATA: begin
        stb.busWr       = 1'b1;
        stb.useOffset   = 1'b1;
        stb.dataFromSrc = 1'b1;
        if (accDone) begin
          stb.clrPoll = 1'b1;
          nextState   = ST_POLL_CMD;
        end
      end
      ST_POLL_CMD: begin
        stb.busWr = 1'b1;
        stb.cmd   = CMD_STATUS_RD;
        if (accDone) nextState = ST_POLL_READ;
      end
      ST_POLL_READ: begin
        stb.busRd = 1'b1;
        if (accDone) begin
          if (devReady) begin
            if (opIsWrite && !lastByte) begin
              stb.incByte = 1'b1;
              nextState   = ST_PG_SETUP;
            end else begin
              nextState = ST_CLEAR;
            end
          end else if (pollExhausted) begin
            stb.setTimeout = 1'b1;
            nextState      = ST_CLEAR;
          end else begin
            stb.incPoll = 1'b1;
            nextState   = ST_POLL_CMD;
          end
        end
      end
      ST_CLEAR: begin
        stb.busWr = 1'b1;
        stb.cmd   = CMD_STATUS_CLR;
        if (accDone) nextState = ST_ARRAY;
      end
      ST_ARRAY: begin
        stb.busWr = 1'b1;
        stb.cmd   = CMD_ARRAY_MODE;
        if (accDone) begin
          stb.clrByte = 1'b1;
          nextState   = ST_VERIFY;
        end
      end
      ST_VERIFY: begin
        stb.busRd     = 1'b1;
        stb.useOffset = 1'b1;
        if (accDone) begin
          if (!readMatch) begin
            stb.setVerifyFail = 1'b1;
            nextState         = ST_FINISH;
          end else if (lastByte) begin
            nextState = ST_FINISH;
          end else begin
            stb.incByte = 1'b1;
          end
        end
      end
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);

  // R2: an accepted start makes the block busy on the next cycle
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9: done lasts one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: busy only drops right after done
  assert_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int BANK_BYTES = 8192,
  parameter int N_BANKS    = 2,
  parameter int ACC_CYC    = 2,
  parameter int GAP_CYC    = 100,
  parameter int POLL_MAX   = 1000000,
  localparam int OFF_W     = $clog2(BANK_BYTES),
  localparam int BANK_W    = $clog2(N_BANKS),
  localparam int ADDR_W    = OFF_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              opWrite,
  input  logic [BANK_W-1:0] bankSel,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              verifyFail,
  output logic [OFF_W-1:0]  srcOffset,
  input  logic [7:0]        srcData,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashDqOut,
  input  logic [7:0]        flashDqIn,
  output logic              flashWeN,
  output logic              flashOeN
);

  seqStrobe_t stb;
  logic accDone, gapDone, devReady, lastByte, pollExhausted, readMatch, opIsWrite;

  flash_seq_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .startOpWrite(opWrite),
    .opIsWrite(opIsWrite), .accDone(accDone), .gapDone(gapDone),
    .devReady(devReady), .lastByte(lastByte), .pollExhausted(pollExhausted),
    .readMatch(readMatch), .stb(stb), .busy(busy), .done(done)
  );

  flash_seq_dp #(
    .BANK_BYTES(BANK_BYTES), .N_BANKS(N_BANKS), .ACC_CYC(ACC_CYC),
    .GAP_CYC(GAP_CYC), .POLL_MAX(POLL_MAX)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .startBank(bankSel),
    .startOpWrite(opWrite), .srcData(srcData), .flashDqIn(flashDqIn),
    .srcOffset(srcOffset), .flashAddr(flashAddr), .flashDqOut(flashDqOut),
    .flashWeN(flashWeN), .flashOeN(flashOeN), .accDone(accDone),
    .gapDone(gapDone), .devReady(devReady), .lastByte(lastByte),
    .pollExhausted(pollExhausted), .readMatch(readMatch),
    .opIsWrite(opIsWrite), .timeoutFlag(timeout), .verifyFailFlag(verifyFail)
  );

endmodule

// File: tb/test_flash_seq.sv
`timescale 1ns/1ps
module test_flash_seq;

  localparam int BYTES  = 16;
  localparam int BANKS  = 2;
  localparam int GAP    = 3;
  localparam int PMAX   = 8;
  localparam int ADDR_W = 5;
  localparam int TOTAL  = BYTES * BANKS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic opWrite = 1'b0;
  logic [0:0] bankSel = '0;
  logic busy, done, timeout, verifyFail;
  logic [3:0] srcOffset;
  logic [7:0] srcData;
  logic [ADDR_W-1:0] flashAddr;
  logic [7:0] flashDqOut, flashDqIn;
  logic flashWeN, flashOeN;

  always #5 clk = ~clk;

  flash_seq #(.BANK_BYTES(BYTES), .N_BANKS(BANKS), .ACC_CYC(2),
              .GAP_CYC(GAP), .POLL_MAX(PMAX)) i_flash_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .opWrite(opWrite),
    .bankSel(bankSel), .busy(busy), .done(done), .timeout(timeout),
    .verifyFail(verifyFail), .srcOffset(srcOffset), .srcData(srcData),
    .flashAddr(flashAddr), .flashDqOut(flashDqOut), .flashDqIn(flashDqIn),
    .flashWeN(flashWeN), .flashOeN(flashOeN)
  );

  // ---------------- data source ----------------
  logic [3:0] seed = '0;
  function automatic logic [7:0] srcByte(input logic [3:0] s, input int off);
    return 8'((s * 29 + off * 7 + 1) & 8'h7F);
  endfunction
  always @(posedge clk) srcData <= srcByte(seed, int'(srcOffset));

  // ---------------- behavioural flash ----------------
  logic [7:0] mem [0:TOTAL-1];
  logic hang = 1'b0, corrupt = 1'b0;
  logic weQ = 1'b1, oeQ = 1'b1;
  logic statusMode = 1'b0, erasePend = 1'b0, progPend = 1'b0;
  logic [ADDR_W-1:0] progAddr = '0;
  int cyc = 0, progCyc = 0, busyCnt = 0;
  int statusReads = 0, progCount = 0, protoErr = 0, minGap = 1000, wildWrites = 0;
  logic [7:0] histA = '0, histB = '0;
  logic [0:0] opBank = '0;
  logic ready;

  assign ready = !hang && (busyCnt == 0);
  assign flashDqIn = statusMode ? {ready, 7'b0} : mem[flashAddr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    weQ <= flashWeN;
    oeQ <= flashOeN;
    if (busyCnt > 0) busyCnt <= busyCnt - 1;
    if (!flashOeN && oeQ && statusMode) statusReads <= statusReads + 1;
    if (!flashWeN && weQ) begin
      histB <= histA;
      histA <= flashDqOut;
      if (flashAddr[ADDR_W-1] != opBank) wildWrites <= wildWrites + 1;
      if (progPend) begin
        progPend <= 1'b0;
        progCount <= progCount + 1;
        if (flashAddr != progAddr) protoErr <= protoErr + 1;
        if (cyc - progCyc < minGap) minGap <= cyc - progCyc;
        if (!hang) mem[flashAddr] <= (corrupt && flashAddr[3:0] == 4'd3) ?
                                     flashDqOut ^ 8'h01 : flashDqOut;
        busyCnt <= 10; statusMode <= 1'b1; statusReads <= 0;
      end else if (erasePend) begin
        erasePend <= 1'b0;
        if (flashDqOut != 8'hD0 || flashAddr[3:0] != 0) protoErr <= protoErr + 1;
        if (!hang) for (int i = 0; i < BYTES; i++)
          mem[flashAddr[ADDR_W-1]*BYTES + i] <= (corrupt && i == 3) ? 8'h00 : 8'hFF;
        busyCnt <= 10; statusMode <= 1'b1; statusReads <= 0;
      end else begin
        case (flashDqOut)
          8'h20: begin erasePend <= 1'b1; if (flashAddr[3:0] != 0) protoErr <= protoErr + 1; end
          8'h40: begin progPend <= 1'b1; progAddr <= flashAddr; progCyc <= cyc; end
          8'h70: begin statusMode <= 1'b1; if (flashAddr[3:0] != 0) protoErr <= protoErr + 1; end
          8'h50: if (flashAddr[3:0] != 0) protoErr <= protoErr + 1;
          8'hFF: begin statusMode <= 1'b0; if (flashAddr[3:0] != 0) protoErr <= protoErr + 1; end
          default: protoErr <= protoErr + 1;
        endcase
      end
    end
  end

  // ---------------- checking ----------------
  int nChecks = 0, nFails = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] snap [0:TOTAL-1];

  task automatic waitDone(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
    if (!seen) check(1'b0, "watchdog", 0, 1);
  endtask

  task automatic launch(input logic op, input logic [0:0] bank, input logic [3:0] sd,
                        input logic hg, input logic cr);
    @(negedge clk);
    for (int i = 0; i < TOTAL; i++) snap[i] = mem[i];
    opWrite = op; bankSel = bank; seed = sd; hang = hg; corrupt = cr; opBank = bank;
    progCount = 0; minGap = 1000; wildWrites = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
  endtask

  // [9] op [8] bank [7:4] seed [3] hang [2] corrupt [1] exp timeout [0] exp verifyFail
  localparam logic [9:0] VECS [0:9] = '{
    {1'b0, 1'b0, 4'd0, 4'b0000}, {1'b1, 1'b0, 4'd1, 4'b0000},
    {1'b0, 1'b1, 4'd0, 4'b0000}, {1'b1, 1'b1, 4'd2, 4'b0000},
    {1'b0, 1'b0, 4'd0, 4'b0101}, {1'b0, 1'b0, 4'd0, 4'b0000},
    {1'b1, 1'b0, 4'd3, 4'b0101}, {1'b0, 1'b1, 4'd0, 4'b1011},
    {1'b0, 1'b1, 4'd0, 4'b0000}, {1'b1, 1'b1, 4'd4, 4'b1011}
  };

  initial begin
    bit seen;
    for (int i = 0; i < TOTAL; i++) mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    // R1: quiet outputs during and after reset
    check(!busy && !done && !timeout && !verifyFail, "R1 flags in reset",
          {busy, done, timeout, verifyFail}, 0);
    check(flashWeN && flashOeN, "R1 strobes in reset", {flashWeN, flashOeN}, 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && flashWeN && flashOeN, "R1 idle after reset",
          {busy, flashWeN, flashOeN}, 3);

    for (int v = 0; v < 10; v++) begin
      logic [9:0] e;
      e = VECS[v];
      launch(e[9], e[8], e[7:4], e[3], e[2]);
      waitDone(seen);
      check(timeout === e[1], "R4 timeout flag", int'(timeout), int'(e[1]));
      check(verifyFail === e[0], "R8 verifyFail flag", int'(verifyFail), int'(e[0]));
      check(histB == 8'h50 && histA == 8'hFF, "R7 clear then array mode",
            {histB, histA}, 16'h50FF);
      check(protoErr == 0, "R3 command protocol", protoErr, 0);
      check(wildWrites == 0, "R3 writes stay in selected bank", wildWrites, 0);
      for (int i = 0; i < BYTES; i++) begin
        int o;
        o = (1 - int'(e[8])) * BYTES + i;
        check(mem[o] == snap[o], "R3 other bank untouched", mem[o], snap[o]);
      end
      if (!e[3] && !e[2]) begin
        for (int i = 0; i < BYTES; i++) begin
          int a;
          a = int'(e[8]) * BYTES + i;
          if (e[9]) check(mem[a] == srcByte(e[7:4], i), "R5 programmed byte",
                          mem[a], srcByte(e[7:4], i));
          else      check(mem[a] == 8'hFF, "R3 erased byte", mem[a], 8'hFF);
        end
      end
      if (e[9] && !e[3]) begin
        check(minGap >= GAP, "R5 settling gap", minGap, GAP);
        check(progCount == BYTES, "R5 one data write per byte", progCount, BYTES);
      end
      if (e[3]) check(statusReads == PMAX, "R4 poll budget", statusReads, PMAX);
      if (e[9] && e[3]) check(progCount == 1, "R6 write aborted", progCount, 1);
      @(negedge clk);
      check(!done && !busy, "R9 done one cycle then idle", {done, busy}, 0);
      repeat (3) @(negedge clk);
      check(timeout === e[1] && verifyFail === e[0], "R9 flags held",
            {timeout, verifyFail}, {e[1], e[0]});
    end

    // R2: a start seen while busy is ignored
    launch(1'b0, 1'b0, 4'd0, 1'b0, 1'b0);
    waitDone(seen);
    launch(1'b1, 1'b0, 4'd5, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    opWrite = 1'b0; bankSel = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(seen);
    for (int i = 0; i < BYTES; i++) begin
      check(mem[i] == srcByte(4'd5, i), "R2 first op completes", mem[i], srcByte(4'd5, i));
      check(mem[BYTES + i] == snap[BYTES + i], "R2 busy start ignored",
            mem[BYTES + i], snap[BYTES + i]);
    end
    check(wildWrites == 0, "R2 no traffic to other bank", wildWrites, 0);
    @(negedge clk);
    check(!busy, "R2 idle afterwards", int'(busy), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    nChecks++; nFails++;
    $display("FAIL watchdog global timeout actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule